// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block works out where a data operand lives for a 16-bit processor with segmented memory. The decoder supplies an addressing-mode code, the pointer, base and index selections, a displacement that is either 8 or 16 bits wide, and an optional segment-override request. The block reads the current BX, BP, SI and DI values and the four segment registers, adds the parts the mode calls for to form a 16-bit effective address, picks a segment, and forms a 20-bit physical address from the shifted segment plus the effective address.

Illegal combinations are flagged rather than passed on. These are an unused mode code, or BP given as the sole pointer of register indirect mode. In that case the valid output drops and both addresses read zero. The arithmetic is combinational and one register stage holds the result, so the bus unit sees the addresses one clock after the inputs were presented.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_n is low, valid_o, ea_o and pa_o are all zero.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R3: For a valid result, pa_o equals segment×16 plus ea_o, modulo 2^20.
- R4: Mode code 0 (direct) gives ea_o equal to the full 16-bit disp_i, whatever disp_wide_i says, with DS as the default segment.
- R5: Mode code 1 (register indirect) takes ea_o from the register named by ptr_sel_i. The codes are 0 for BX, 1 for SI and 2 for DI. Code 3 (BP) is illegal.
- R6: Mode code 2 (register relative) adds the displacement to the ptr_sel_i register, with code 3 meaning BP. When disp_wide_i is 0, only disp_i[7:0] is used, sign-extended to 16 bits.
- R7: Mode code 3 (based indexed) adds the base register to the index register. base_sel_i=0 selects BX and 1 selects BP. idx_sel_i=0 selects SI and 1 selects DI.
- R8: Mode code 4 (relative based indexed) adds base, index and displacement. The effective-address sum wraps modulo 2^16.
- R9: With no override, a mode whose base or pointer is BP uses SS, and every other mode uses DS.
- R10: When seg_ovr_en_i is 1, seg_ovr_sel_i picks the segment, overriding any default. The codes are 0 for ES, 1 for CS, 2 for SS and 3 for DS.
- R11: Mode codes 5, 6 and 7 are illegal. For these, and for the illegal case in R5, valid_o is 0 and ea_o and pa_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Addressing-mode code |
| ptr_sel_i | input | 2 | Single pointer register selection |
| base_sel_i | input | 1 | Base register selection, BX or BP |
| idx_sel_i | input | 1 | Index register selection, SI or DI |
| disp_wide_i | input | 1 | 1 selects a 16-bit displacement, 0 an 8-bit one |
| disp_i | input | 16 | Displacement, or the direct offset |
| seg_ovr_en_i | input | 1 | Segment override request |
| seg_ovr_sel_i | input | 2 | Override segment code |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| es_i | input | 16 | ES value |
| cs_i | input | 16 | CS value |
| ss_i | input | 16 | SS value |
| ds_i | input | 16 | DS value |
| ea_o | output | 16 | Registered effective address |
| pa_o | output | 20 | Registered physical address |
| valid_o | output | 1 | Registered legality flag |

## Verification
The bench targets several corner cases:
- A narrow displacement of 0x80 or above, which a design without sign extension would turn into a large positive offset.
- Base, index and displacement sums that cross 0xFFFF, which catch a design that carries into bit 16.
- A segment of 0xFFFF with a high offset, which exposes a physical address that is not truncated to 20 bits.
- BP-based modes with and without override, which catch a wrong default of DS or an override that loses to the default.
- BP as the indirect pointer and the three unused mode codes, which must give zero addresses with valid low instead of a stale or partial sum.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT       = 3'd0,
    AM_REG_IND      = 3'd1,
    AM_REG_REL      = 3'd2,
    AM_BASE_IDX     = 3'd3,
    AM_REL_BASE_IDX = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    PTR_BX = 2'd0,
    PTR_SI = 2'd1,
    PTR_DI = 2'd2,
    PTR_BP = 2'd3
  } ptr_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

endpackage

// File: rtl/sa_ea_unit.sv
module sa_ea_unit
  import seg_addr_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic             base_sel,
  input  logic             idx_sel,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  output logic [OFS_W-1:0] ea,
  output logic             legal,
  output logic             uses_bp
);

  localparam int EXT_W = OFS_W - NARROW_W;

  function automatic logic [OFS_W-1:0] fit_disp(input logic [OFS_W-1:0] d,
                                                input logic wide);
    if (wide) return d;
    return {{EXT_W{d[NARROW_W-1]}}, d[NARROW_W-1:0]};
  endfunction

  function automatic logic [OFS_W-1:0] add3(input logic [OFS_W-1:0] a,
                                            input logic [OFS_W-1:0] b,
                                            input logic [OFS_W-1:0] c);
    return a + b + c;
  endfunction

  logic [OFS_W-1:0] ptr_val, base_val, idx_val, disp_x;

  always_comb begin
    case (ptr_sel)
      PTR_BX:  ptr_val = bx;
      PTR_SI:  ptr_val = si;
      PTR_DI:  ptr_val = di;
      default: ptr_val = bp;
    endcase
    base_val = base_sel ? bp : bx;
    idx_val  = idx_sel  ? di : si;
    disp_x   = fit_disp(disp, disp_wide);
  end

  always_comb begin
    ea      = '0;
    legal   = 1'b1;
    uses_bp = 1'b0;
    case (mode)
      AM_DIRECT: ea = disp;
      AM_REG_IND: begin
        legal = (ptr_sel != PTR_BP);
        ea    = legal ? ptr_val : '0;
      end
      AM_REG_REL: begin
        ea      = add3(ptr_val, disp_x, '0);
        uses_bp = (ptr_sel == PTR_BP);
      end
      AM_BASE_IDX: begin
        ea      = add3(base_val, idx_val, '0);
        uses_bp = base_sel;
      end
      AM_REL_BASE_IDX: begin
        ea      = add3(base_val, idx_val, disp_x);
        uses_bp = base_sel;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sa_seg_pick.sv
module sa_seg_pick
  import seg_addr_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             uses_bp,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [OFS_W-1:0] es,
  input  logic [OFS_W-1:0] cs,
  input  logic [OFS_W-1:0] ss,
  input  logic [OFS_W-1:0] ds,
  output logic [1:0]       seg_code,
  output logic [OFS_W-1:0] seg_val
);

  always_comb begin
    if (ovr_en)       seg_code = ovr_sel;
    else if (uses_bp) seg_code = SEG_SS;
    else              seg_code = SEG_DS;
    case (seg_code)
      SEG_ES:  seg_val = es;
      SEG_CS:  seg_val = cs;
      SEG_SS:  seg_val = ss;
      default: seg_val = ds;
    endcase
  end

endmodule

// File: rtl/sa_pa_unit.sv
module sa_pa_unit #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFS_W-1:0]           seg,
  input  logic [OFS_W-1:0]           ea,
  output logic [OFS_W+SEG_SHIFT-1:0] pa
);

  localparam int PA_W = OFS_W + SEG_SHIFT;

  function automatic logic [PA_W-1:0] phys(input logic [OFS_W-1:0] s,
                                           input logic [OFS_W-1:0] e);
    logic [PA_W-1:0] shifted;
    logic [PA_W-1:0] widened;
    shifted = {s, {SEG_SHIFT{1'b0}}};
    widened = {{SEG_SHIFT{1'b0}}, e};
    return shifted + widened;
  endfunction

  assign pa = phys(seg, ea);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int NARROW_W  = 8,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 mode_i,
  input  logic [1:0]                 ptr_sel_i,
  input  logic                       base_sel_i,
  input  logic                       idx_sel_i,
  input  logic                       disp_wide_i,
  input  logic [OFS_W-1:0]           disp_i,
  input  logic                       seg_ovr_en_i,
  input  logic [1:0]                 seg_ovr_sel_i,
  input  logic [OFS_W-1:0]           bx_i,
  input  logic [OFS_W-1:0]           bp_i,
  input  logic [OFS_W-1:0]           si_i,
  input  logic [OFS_W-1:0]           di_i,
  input  logic [OFS_W-1:0]           es_i,
  input  logic [OFS_W-1:0]           cs_i,
  input  logic [OFS_W-1:0]           ss_i,
  input  logic [OFS_W-1:0]           ds_i,
  output logic [OFS_W-1:0]           ea_o,
  output logic [OFS_W+SEG_SHIFT-1:0] pa_o,
  output logic                       valid_o
);

  localparam int PA_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0] ea_comb;
  logic             ea_legal;
  logic             uses_bp;
  logic [1:0]       seg_code;
  logic [OFS_W-1:0] seg_val;
  logic [PA_W-1:0]  pa_comb;

  sa_ea_unit #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_ea (
    .mode(mode_i), .ptr_sel(ptr_sel_i), .base_sel(base_sel_i),
    .idx_sel(idx_sel_i), .disp_wide(disp_wide_i), .disp(disp_i),
    .bx(bx_i), .bp(bp_i), .si(si_i), .di(di_i),
    .ea(ea_comb), .legal(ea_legal), .uses_bp(uses_bp)
  );

  sa_seg_pick #(.OFS_W(OFS_W)) u_seg (
    .uses_bp(uses_bp), .ovr_en(seg_ovr_en_i), .ovr_sel(seg_ovr_sel_i),
    .es(es_i), .cs(cs_i), .ss(ss_i), .ds(ds_i),
    .seg_code(seg_code), .seg_val(seg_val)
  );

  sa_pa_unit #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
    .seg(seg_val), .ea(ea_comb), .pa(pa_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_o    <= '0;
      pa_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ea_legal;
      ea_o    <= ea_legal ? ea_comb : '0;
      pa_o    <= ea_legal ? pa_comb : '0;
    end
  end

endmodule

// File: rtl/sa_chk.sv
module sa_chk
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 mode_i,
  input logic [1:0]                 ptr_sel_i,
  input logic [OFS_W-1:0]           disp_i,
  input logic                       seg_ovr_en_i,
  input logic [OFS_W-1:0]           ss_i,
  input logic [OFS_W-1:0]           ds_i,
  input logic                       ea_legal,
  input logic                       uses_bp,
  input logic [OFS_W-1:0]           seg_val,
  input logic [OFS_W-1:0]           ea_o,
  input logic [OFS_W+SEG_SHIFT-1:0] pa_o,
  input logic                       valid_o
);

  localparam int PA_W = OFS_W + SEG_SHIFT;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && ea_o == '0 && pa_o == '0));

  // R2
  one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_o == $past(ea_legal)));

  // R3
  pa_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pa_o == (PA_W'($past(seg_val)) << SEG_SHIFT) + PA_W'(ea_o)));

  // R4
  direct_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == AM_DIRECT) |=> (valid_o && ea_o == $past(disp_i)));

  // R5
  ind_bp_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == AM_REG_IND && ptr_sel_i == PTR_BP) |=> (!valid_o && ea_o == '0));

  // R9
  bp_stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_legal && !seg_ovr_en_i) |-> (seg_val == (uses_bp ? ss_i : ds_i)));

  // R11
  bad_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > 3'd4) |=> (!valid_o && ea_o == '0 && pa_o == '0));

endmodule

bind seg_addr_gen sa_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_sa_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ptr_sel_i(ptr_sel_i),
  .disp_i(disp_i), .seg_ovr_en_i(seg_ovr_en_i), .ss_i(ss_i), .ds_i(ds_i),
  .ea_legal(ea_legal), .uses_bp(uses_bp), .seg_val(seg_val),
  .ea_o(ea_o), .pa_o(pa_o), .valid_o(valid_o)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr = '0;
  logic        bsel = 1'b0, isel = 1'b0, wide = 1'b0;
  logic [15:0] disp = '0;
  logic        oen = 1'b0;
  logic [1:0]  osel = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0;
  logic [15:0] es = '0, cs = '0, ss = '0, ds = '0;
  logic [15:0] ea_o;
  logic [19:0] pa_o;
  logic        valid_o;

  int n_checks = 0;
  int n_fail = 0;

  int    q_ea[$];
  int    q_pa[$];
  bit    q_v[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ptr_sel_i(ptr),
    .base_sel_i(bsel), .idx_sel_i(isel), .disp_wide_i(wide), .disp_i(disp),
    .seg_ovr_en_i(oen), .seg_ovr_sel_i(osel),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di),
    .es_i(es), .cs_i(cs), .ss_i(ss), .ds_i(ds),
    .ea_o(ea_o), .pa_o(pa_o), .valid_o(valid_o)
  );

  // Behavioural reference built from the requirements with plain integers.
  function automatic void predict(output int e, output int p, output bit v);
    int d, sum, seg;
    bit on_bp;
    d = wide ? int'(disp) : int'(disp[7:0]);
    if (!wide && d >= 128) d = d - 256;
    v = 1; on_bp = 0; sum = 0;
    if (mode == 3'd0) sum = int'(disp);
    else if (mode == 3'd1) begin
      if (ptr == 2'd0) sum = int'(bx);
      else if (ptr == 2'd1) sum = int'(si);
      else if (ptr == 2'd2) sum = int'(di);
      else v = 0;
    end else if (mode == 3'd2) begin
      if (ptr == 2'd0) sum = int'(bx);
      else if (ptr == 2'd1) sum = int'(si);
      else if (ptr == 2'd2) sum = int'(di);
      else begin sum = int'(bp); on_bp = 1; end
      sum = sum + d;
    end else if (mode == 3'd3 || mode == 3'd4) begin
      sum = (bsel ? int'(bp) : int'(bx)) + (isel ? int'(di) : int'(si));
      on_bp = bsel;
      if (mode == 3'd4) sum = sum + d;
    end else v = 0;
    e = ((sum % 65536) + 65536) % 65536;
    if (oen) seg = (osel == 0) ? int'(es) : (osel == 1) ? int'(cs) :
                   (osel == 2) ? int'(ss) : int'(ds);
    else seg = on_bp ? int'(ss) : int'(ds);
    p = (seg * 16 + e) % 1048576;
    if (!v) begin e = 0; p = 0; end
  endfunction

  task automatic compare_pending();
    int e, p;
    bit v;
    string t;
    if (q_v.size() == 0) return;
    e = q_ea.pop_front(); p = q_pa.pop_front();
    v = q_v.pop_front(); t = q_tag.pop_front();
    n_checks++;
    if (int'(ea_o) != e || int'(pa_o) != p || valid_o != v) begin
      n_fail++;
      $display("FAIL %s: got ea=%h pa=%h v=%0d expected ea=%h pa=%h v=%0d",
               t, ea_o, pa_o, valid_o, e[15:0], p[19:0], v);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [1:0] pr,
                       input logic bs, input logic is, input logic w,
                       input logic [15:0] d, input logic oe,
                       input logic [1:0] os, input string tag);
    int e, p;
    bit v;
    @(negedge clk);
    compare_pending();
    mode = m; ptr = pr; bsel = bs; isel = is; wide = w;
    disp = d; oen = oe; osel = os;
    predict(e, p, v);
    q_ea.push_back(e); q_pa.push_back(p); q_v.push_back(v); q_tag.push_back(tag);
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic o);
    string s;
    case (m)
      3'd0: s = "R4";
      3'd1: s = "R5";
      3'd2: s = "R6";
      3'd3: s = "R7";
      3'd4: s = "R8";
      default: s = "R11";
    endcase
    return o ? {s, "/R10"} : {s, "/R9/R3"};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  %0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    bx = 16'h1000; bp = 16'h2000; si = 16'h0030; di = 16'h0400;
    es = 16'h3000; cs = 16'h4000; ss = 16'h5000; ds = 16'h1234;
    mode = 3'd2; disp = 16'h00FF; wide = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset even with live inputs
    n_checks++;
    if (valid_o !== 1'b0 || ea_o !== 16'h0 || pa_o !== 20'h0) begin
      n_fail++;
      $display("FAIL R1: got ea=%h pa=%h v=%0d expected zeros", ea_o, pa_o, valid_o);
    end
    rst_n = 1'b1;

    // R2: back-to-back vectors, each visible exactly one cycle later
    drive(3'd0, 2'd0, 0, 0, 0, 16'h5678, 0, 2'd0, "R2/R4");
    drive(3'd0, 2'd0, 0, 0, 1, 16'h0001, 0, 2'd0, "R2/R4");
    // R10: direct with ES override
    drive(3'd0, 2'd0, 0, 0, 0, 16'h0010, 1, 2'd0, "R10");
    // R5: each legal pointer and BP
    drive(3'd1, 2'd0, 0, 0, 0, 16'h0000, 0, 2'd0, "R5");
    drive(3'd1, 2'd1, 0, 0, 0, 16'h0000, 0, 2'd0, "R5");
    drive(3'd1, 2'd2, 0, 0, 0, 16'h0000, 0, 2'd0, "R5");
    drive(3'd1, 2'd3, 0, 0, 0, 16'h0000, 0, 2'd0, "R5/R11");
    // R6/R9: BP relative with negative narrow displacement, SS default
    drive(3'd2, 2'd3, 0, 0, 0, 16'h1280, 0, 2'd0, "R6/R9");
    drive(3'd2, 2'd1, 0, 0, 1, 16'h8000, 0, 2'd0, "R6");
    drive(3'd2, 2'd0, 0, 0, 0, 16'hFF7F, 0, 2'd0, "R6");
    // R7/R9
    drive(3'd3, 2'd0, 0, 0, 0, 16'h0000, 0, 2'd0, "R7");
    drive(3'd3, 2'd0, 1, 1, 0, 16'h0000, 0, 2'd0, "R7/R9");
    // R10: BP base but DS override
    drive(3'd3, 2'd0, 1, 0, 0, 16'h0000, 1, 2'd3, "R10");
    drive(3'd4, 2'd0, 1, 1, 0, 16'h0005, 1, 2'd1, "R10");
    // R8: wrap of EA
    @(negedge clk); compare_pending();
    bx = 16'hFFF0; si = 16'h0020;
    q_ea.push_back(0); q_ea.pop_back();
    drive(3'd4, 2'd0, 0, 0, 1, 16'h0010, 0, 2'd0, "R8");
    drive(3'd4, 2'd0, 0, 0, 0, 16'h00F0, 0, 2'd0, "R8");
    // R3: PA wrap at 2^20
    @(negedge clk); compare_pending();
    ds = 16'hFFFF;
    drive(3'd0, 2'd0, 0, 0, 0, 16'hFFFF, 0, 2'd0, "R3");
    // R11: unused codes
    drive(3'd5, 2'd0, 0, 0, 0, 16'h1111, 0, 2'd0, "R11");
    drive(3'd6, 2'd1, 1, 1, 1, 16'h2222, 1, 2'd2, "R11");
    drive(3'd7, 2'd2, 0, 1, 0, 16'h3333, 0, 2'd0, "R11");

    for (int k = 0; k < 400; k++) begin
      logic [2:0] m;
      logic o;
      @(negedge clk); compare_pending();
      bx = 16'($urandom); bp = 16'($urandom); si = 16'($urandom); di = 16'($urandom);
      es = 16'($urandom); cs = 16'($urandom); ss = 16'($urandom); ds = 16'($urandom);
      m = 3'($urandom_range(0, 7));
      o = 1'($urandom);
      drive(m, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            16'($urandom), o, 2'($urandom), tag_of(m, o));
    end
    @(negedge clk); compare_pending();

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule